// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable counter of a processor's performance-monitoring unit. On every clock it receives increment counts for a set of hardware events. Each event group has eight sub-event lanes, and each lane carries a small per-cycle count. The lanes arrive twice: once for the local logical processor and once for the other logical processors in the package. A configuration word picks one event group by an 8-bit code and a subset of its lanes by an 8-bit unit mask. The selected per-cycle total is then qualified before it reaches a 48-bit accumulator.

Qualification works in this order:

- a per-cycle threshold comparison, which can be inverted;
- an optional rising-edge mode that counts occurrences instead of cycles;
- supervisor and user privilege filters;
- a global enable.

Software programs the configuration through a small register port and can read or overwrite the count. It also reads and clears a sticky wrap flag, which drives an interrupt line when the interrupt enable is set.

Top module: `evq_counter`

## Requirements
- R1: After a synchronous active-low reset, the configuration word, the count, the wrap flag and `irq` are all zero.
- R2: Configuration word layout (register address 0, bits 31:0): code [7:0], unit mask [15:8], user enable [16], supervisor enable [17], edge mode [18], interrupt enable [19], any-thread [20], enable [21], invert [22], spare [23] (stored and read back), threshold [31:24]. The per-cycle total is the sum of the lanes of group `code` whose unit-mask bit is set. Lane `s` of group `c` sits at `evt_local[(c*8+s)*INC_W +: INC_W]`. A code of `NUM_CODES` or above selects nothing.
- R3: With threshold 0, invert 0 and edge 0, each qualifying cycle adds the full per-cycle total to the count.
- R4: With a nonzero threshold, a qualifying cycle adds exactly one when the total is greater than or equal to the threshold, and adds nothing otherwise.
- R5: Invert reverses the condition. With a threshold, the counter adds one when the total is below it. With threshold 0, it adds one when the total is zero.
- R6: In edge mode, the counter adds one only in a cycle where the qualified condition is true and was false in the previous cycle.
- R7: A cycle at privilege level 0 qualifies only if the supervisor enable is set. A cycle at levels 1 to 3 qualifies only if the user enable is set.
- R8: The remote lanes (`evt_remote`, same layout) join the total only when any-thread is set.
- R9: With enable clear, the count does not change, except by a software write.
- R10: A configuration write takes effect from the next cycle and clears the edge history, so a condition that is already true counts again at once.
- R11: A write to address 1 loads the count on the next cycle and overrides any increment in that cycle. Address 1 reads the count, and address 3 reads zero.
- R12: When an increment carries the count past all-ones, the wrap flag (address 2, bit 0) is set. A write to address 2 with bit 0 set clears the flag, but a new wrap in the same cycle wins. `irq` equals the flag AND the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_local | input | NUM_CODES*8*INC_W | Per-cycle lane counts, local logical processor |
| evt_remote | input | NUM_CODES*8*INC_W | Per-cycle lane counts, other logical processors |
| priv_lvl | input | 2 | Current privilege level (0 = supervisor) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 config, 1 count, 2 status |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address (combinational read) |
| rd_data | output | CNT_W | Read data |
| irq | output | 1 | Wrap interrupt |

## Verification
The bench targets the points where counting modes meet.

- **Threshold ties.** A total exactly equal to the threshold must count. A `>` comparison would undercount on those cycles.
- **Invert with threshold 0.** This must count idle cycles. A design that ignores invert when the threshold is zero would count nothing.
- **Edge mode under a held-true condition.** Repeated configuration writes against a constant true condition expose a design that keeps stale edge history, because it would miss the recount after each write.
- **Wrap and clear collisions.** A count load is placed in the same cycle as live increments, and the count wraps near all-ones with the interrupt enable both on and off. A wrong priority or a lost carry then shows as a count or flag mismatch in that very cycle.

// File: rtl/evq_pkg.sv
// Package: shared configuration layout and register addresses for the
// qualified event counter. Assumes a 32-bit configuration word.
package evq_pkg;

    // Configuration word, bit 31 down to bit 0.
    typedef struct packed {
        logic [7:0] cmask;    // threshold; 0 means "sum mode"
        logic       spare;    // stored, no function
        logic       inv;      // invert the condition
        logic       en;       // global enable
        logic       any;      // include other logical processors
        logic       ie;       // interrupt enable
        logic       edge_md;  // count false->true transitions
        logic       os_en;    // count at level 0
        logic       usr_en;   // count at levels 1..3
        logic [7:0] umask;    // sub-event lane mask
        logic [7:0] code;     // event group
    } evq_cfg_t;

    typedef enum logic [1:0] {
        MODE_SUM   = 2'd0,
        MODE_LEVEL = 2'd1,
        MODE_EDGE  = 2'd2
    } evq_mode_e;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_STS = 2'd2;

endpackage

// File: rtl/evq_select.sv
// Event selection: picks one event group by code and sums the lanes
// enabled in the unit mask, optionally adding the remote lanes.
// Assumes flat lane vectors indexed as (code*MASK_W + lane)*INC_W.
module evq_select #(
    parameter int NUM_CODES = 4,
    parameter int MASK_W    = 8,
    parameter int INC_W     = 2,
    parameter int SUM_W     = 6,
    parameter int EVT_W     = NUM_CODES * MASK_W * INC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_local,
    input  logic [EVT_W-1:0]  evt_remote,
    input  logic [7:0]        code,
    input  logic [MASK_W-1:0] umask,
    input  logic              any_thread,
    output logic [SUM_W-1:0]  sum
);

    logic [SUM_W-1:0] part [MASK_W];

    for (genvar s = 0; s < MASK_W; s++) begin : g_lane
        logic [INC_W-1:0] loc;
        logic [INC_W-1:0] rem;

        // Pick this lane from the group named by the code.
        always_comb begin
            loc = '0;
            rem = '0;
            for (int c = 0; c < NUM_CODES; c++) begin
                if (code == 8'(c)) begin
                    loc = evt_local[(c*MASK_W+s)*INC_W +: INC_W];
                    rem = evt_remote[(c*MASK_W+s)*INC_W +: INC_W];
                end
            end
        end

        assign part[s] = umask[s] ? (SUM_W'(loc) + (any_thread ? SUM_W'(rem) : '0)) : '0;
    end

    // Add the masked lanes together.
    always_comb begin
        sum = '0;
        for (int s = 0; s < MASK_W; s++) begin
            sum = sum + part[s];
        end
    end

    // R2
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (umask == '0) |-> (sum == '0));

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= 8'(NUM_CODES)) |-> (sum == '0));

endmodule

// File: rtl/evq_qualify.sv
// Qualification: turns the per-cycle total into an increment using the
// threshold, invert, edge, privilege and enable controls. Holds one bit
// of edge history, cleared on any configuration write.
module evq_qualify
    import evq_pkg::*;
#(
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             os_en,
    input  logic             usr_en,
    input  logic             edge_md,
    input  logic             inv,
    input  logic [7:0]       cmask,
    input  logic [1:0]       priv_lvl,
    input  logic [SUM_W-1:0] sum,
    input  logic             hist_clr,
    output logic [SUM_W-1:0] inc
);

    localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8;

    logic      priv_ok;
    logic      thr_on;
    logic      raw;
    logic      cond_q;
    logic      prev_q;
    evq_mode_e mode;

    // Evaluate the qualified condition for this cycle.
    always_comb begin
        priv_ok = (priv_lvl == 2'd0) ? os_en : usr_en;
        thr_on  = (cmask != 8'd0);
        raw     = thr_on ? (CMP_W'(sum) >= CMP_W'(cmask)) : (sum != '0);
        cond_q  = en & priv_ok & (raw ^ inv);
    end

    // Choose the counting mode.
    always_comb begin
        if (edge_md)             mode = MODE_EDGE;
        else if (thr_on || inv)  mode = MODE_LEVEL;
        else                     mode = MODE_SUM;
    end

    // Form the increment for the selected mode.
    always_comb begin
        case (mode)
            MODE_EDGE:  inc = (cond_q && !prev_q) ? SUM_W'(1) : '0;
            MODE_LEVEL: inc = cond_q ? SUM_W'(1) : '0;
            default:    inc = (en && priv_ok) ? sum : '0;
        endcase
    end

    // Edge history: last cycle's qualified condition.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (hist_clr) prev_q <= 1'b0;
        else               prev_q <= cond_q;
    end

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (inc == '0));

    // R4
    thresh_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmask != 8'd0) |-> (inc <= SUM_W'(1)));

    // R6
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md && inc != '0 && !hist_clr) |=> (inc == '0 || !edge_md));

endmodule

// File: rtl/evq_accum.sv
// Accumulator: 48-bit (parameterised) count with software load priority
// and a sticky wrap flag that the status write clears.
module evq_accum #(
    parameter int CNT_W = 48,
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] nxt;
    logic             carry;

    // Next count and its carry out.
    always_comb begin
        {carry, nxt} = EXT_W'(cnt) + EXT_W'(inc);
    end

    // Count register: a load beats an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ld) cnt <= ld_val;
        else         cnt <= nxt;
    end

    // Sticky wrap flag: a new wrap beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovf <= 1'b0;
        else if (!ld && carry)   ovf <= 1'b1;
        else if (ovf_clr)        ovf <= 1'b0;
    end

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt == $past(ld_val)));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R12
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && !ld && cnt == '1 && inc != '0) |=> ovf);

endmodule

// File: rtl/evq_counter.sv
// Top: one qualified programmable event counter. Holds the configuration
// register, decodes register writes, drives the read mux and interrupt.
// Assumes CNT_W >= 32 so that the configuration fits the data bus.
module evq_counter
    import evq_pkg::*;
#(
    parameter int NUM_CODES = 4,
    parameter int INC_W     = 2,
    parameter int CNT_W     = 48,
    parameter int MASK_W    = 8,
    parameter int EVT_W     = NUM_CODES * MASK_W * INC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_local,
    input  logic [EVT_W-1:0] evt_remote,
    input  logic [1:0]       priv_lvl,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);

    localparam int MAX_SUM = 2 * MASK_W * ((1 << INC_W) - 1);
    localparam int SUM_W   = $clog2(MAX_SUM + 1);

    evq_cfg_t         cfg_q;
    logic             cfg_wr;
    logic             cnt_wr;
    logic             sts_clr;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] inc;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    // Decode register writes.
    always_comb begin
        cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
        cnt_wr  = wr_en && (wr_addr == ADDR_CNT);
        sts_clr = wr_en && (wr_addr == ADDR_STS) && wr_data[0];
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= evq_cfg_t'(wr_data[31:0]);
    end

    evq_select #(
        .NUM_CODES (NUM_CODES),
        .MASK_W    (MASK_W),
        .INC_W     (INC_W),
        .SUM_W     (SUM_W)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_local  (evt_local),
        .evt_remote (evt_remote),
        .code       (cfg_q.code),
        .umask      (cfg_q.umask),
        .any_thread (cfg_q.any),
        .sum        (sum)
    );

    evq_qualify #(
        .SUM_W (SUM_W)
    ) u_qualify (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_q.en),
        .os_en    (cfg_q.os_en),
        .usr_en   (cfg_q.usr_en),
        .edge_md  (cfg_q.edge_md),
        .inv      (cfg_q.inv),
        .cmask    (cfg_q.cmask),
        .priv_lvl (priv_lvl),
        .sum      (sum),
        .hist_clr (cfg_wr),
        .inc      (inc)
    );

    evq_accum #(
        .CNT_W (CNT_W),
        .SUM_W (SUM_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .ld      (cnt_wr),
        .ld_val  (wr_data),
        .ovf_clr (sts_clr),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    // Read mux.
    always_comb begin
        case (rd_addr)
            ADDR_CFG: rd_data = CNT_W'(cfg_q);
            ADDR_CNT: rd_data = cnt;
            ADDR_STS: rd_data = CNT_W'(ovf);
            default:  rd_data = '0;
        endcase
    end

    // Interrupt output.
    assign irq = ovf & cfg_q.ie;

    // R10
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(wr_data[31:0])));

    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |-> !irq);

endmodule

// File: tb/evq_counter_bench.sv
// Bench: behavioural reference model updated on each rising edge and
// compared against rd_data and irq on every falling edge.
module evq_counter_bench;

    localparam int NC    = 4;
    localparam int IW    = 2;
    localparam int CW    = 48;
    localparam int EW    = NC * 8 * IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [EW-1:0] evt_local = '0;
    logic [EW-1:0] evt_remote = '0;
    logic [1:0]    priv_lvl = 2'd0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = 2'd1;
    logic [CW-1:0] rd_data;
    logic          irq;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";
    bit    done = 0;

    // Reference state.
    logic [31:0]     m_cfg = '0;
    longint unsigned m_cnt = 0;
    bit              m_ovf = 0;
    bit              m_prev = 0;

    evq_counter #(.NUM_CODES(NC), .INC_W(IW), .CNT_W(CW)) u_evq_counter (
        .clk(clk), .rst_n(rst_n), .evt_local(evt_local), .evt_remote(evt_remote),
        .priv_lvl(priv_lvl), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [47:0] mk(input int code, input int umask, input int cmask,
                                       input bit inv, input bit en, input bit any, input bit ie,
                                       input bit edg, input bit os, input bit usr);
        logic [31:0] w;
        w = {cmask[7:0], 1'b0, inv, en, any, ie, edg, os, usr, umask[7:0], code[7:0]};
        return {16'h0, w};
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        int  code, tot, cm, inc;
        bit  pok, raw, q;
        longint unsigned t;
        if (!rst_n) begin
            m_cfg = '0; m_cnt = 0; m_ovf = 0; m_prev = 0;
        end else begin
            code = m_cfg[7:0];
            tot = 0;
            if (code < NC) begin
                for (int s = 0; s < 8; s++) begin
                    if (m_cfg[8+s]) begin
                        tot += evt_local[(code*8+s)*IW +: IW];
                        if (m_cfg[20]) tot += evt_remote[(code*8+s)*IW +: IW];
                    end
                end
            end
            cm  = m_cfg[31:24];
            pok = (priv_lvl == 0) ? m_cfg[17] : m_cfg[16];
            raw = (cm != 0) ? (tot >= cm) : (tot != 0);
            q   = m_cfg[21] && pok && (raw ^ m_cfg[22]);
            if (m_cfg[18])                 inc = (q && !m_prev) ? 1 : 0;
            else if (cm != 0 || m_cfg[22]) inc = q ? 1 : 0;
            else                           inc = (m_cfg[21] && pok) ? tot : 0;
            if (wr_en && wr_addr == 2'd1) begin
                m_cnt = wr_data;
            end else begin
                t = m_cnt + longint'(inc);
                if (t >= (64'd1 << 48)) begin
                    t -= (64'd1 << 48);
                    m_ovf = 1;
                end else if (wr_en && wr_addr == 2'd2 && wr_data[0]) begin
                    m_ovf = 0;
                end
                m_cnt = t;
            end
            if (wr_en && wr_addr == 2'd2 && wr_data[0] && (wr_en && wr_addr == 2'd1))
                m_ovf = 0;
            if (wr_en && wr_addr == 2'd0) begin
                m_cfg = wr_data[31:0];
                m_prev = 0;
            end else begin
                m_prev = q;
            end
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        logic [CW-1:0] exp_rd;
        bit            exp_irq;
        if (rst_n && !done) begin
            case (rd_addr)
                2'd0:    exp_rd = {16'h0, m_cfg};
                2'd1:    exp_rd = m_cnt[47:0];
                2'd2:    exp_rd = {47'h0, m_ovf};
                default: exp_rd = '0;
            endcase
            exp_irq = m_ovf & m_cfg[19];
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL %s rd_addr=%0d rd_data=%h expected=%h", phase, rd_addr, rd_data, exp_rd);
            end
            checks++;
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL %s irq=%0b expected=%0b", phase, irq, exp_irq);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [47:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic run_rand(input int n);
        for (int i = 0; i < n; i++) begin
            evt_local  = {$urandom, $urandom};
            evt_remote = {$urandom, $urandom};
            priv_lvl   = 2'($urandom);
            tick();
        end
    endtask

    task automatic peek_all();
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            tick();
        end
        rd_addr = 2'd1;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        phase = "R1";
        peek_all();

        phase = "R3";
        wr(2'd0, mk(1, 8'h0F, 0, 0, 1, 0, 0, 0, 1, 1));
        run_rand(40);
        phase = "R2";
        wr(2'd0, mk(3, 8'hA5, 0, 0, 1, 0, 0, 0, 1, 1));
        run_rand(30);
        wr(2'd0, mk(9, 8'hFF, 0, 0, 1, 1, 0, 0, 1, 1));
        run_rand(20);
        peek_all();

        phase = "R4";
        wr(2'd0, mk(0, 8'hFF, 24, 0, 1, 0, 0, 0, 1, 1));
        run_rand(40);
        wr(2'd0, mk(2, 8'h0F, 4, 0, 1, 0, 0, 0, 1, 1));
        run_rand(40);

        phase = "R5";
        wr(2'd0, mk(0, 8'hFF, 12, 1, 1, 0, 0, 0, 1, 1));
        run_rand(40);
        wr(2'd0, mk(1, 8'h01, 0, 1, 1, 0, 0, 0, 1, 1));
        run_rand(30);

        phase = "R6";
        wr(2'd0, mk(0, 8'h03, 2, 0, 1, 0, 0, 1, 1, 1));
        run_rand(40);
        wr(2'd0, mk(1, 8'h01, 0, 0, 1, 0, 0, 1, 1, 1));
        run_rand(30);

        phase = "R7";
        wr(2'd0, mk(2, 8'hFF, 0, 0, 1, 0, 0, 0, 1, 0));
        run_rand(30);
        wr(2'd0, mk(2, 8'hFF, 0, 0, 1, 0, 0, 0, 0, 1));
        run_rand(30);

        phase = "R8";
        wr(2'd0, mk(3, 8'hFF, 0, 0, 1, 1, 0, 0, 1, 1));
        run_rand(30);
        wr(2'd0, mk(3, 8'hFF, 30, 0, 1, 1, 0, 0, 1, 1));
        run_rand(30);

        phase = "R9";
        wr(2'd0, mk(0, 8'hFF, 0, 0, 0, 1, 0, 0, 1, 1));
        run_rand(20);

        phase = "R10";
        evt_local = '1; evt_remote = '1; priv_lvl = 2'd0;
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, mk(0, 8'hFF, 1, 0, 1, 0, 0, 1, 1, 1));
            tick(); tick();
        end
        peek_all();

        phase = "R11";
        wr(2'd0, mk(0, 8'hFF, 0, 0, 1, 1, 0, 0, 1, 1));
        tick();
        wr(2'd1, 48'd1234);
        run_rand(5);
        wr(2'd1, 48'h0000_FFFF_0000);
        peek_all();

        phase = "R12";
        evt_local = '1; evt_remote = '1;
        wr(2'd0, mk(0, 8'hFF, 0, 0, 1, 1, 1, 0, 1, 1));
        wr(2'd1, 48'hFFFF_FFFF_FF00);
        repeat (8) tick();
        peek_all();
        wr(2'd2, 48'd0);
        tick();
        wr(2'd2, 48'd1);
        tick();
        wr(2'd1, 48'hFFFF_FFFF_FFF0);
        wr(2'd2, 48'd1);
        tick();
        wr(2'd0, mk(0, 8'hFF, 0, 0, 1, 1, 0, 0, 1, 1));
        wr(2'd1, 48'hFFFF_FFFF_FFF0);
        repeat (3) tick();
        peek_all();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog phase %s actual=hung expected=finished", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule